// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small non-pipelined processor. In every clock one instruction goes the whole way through the core. It is fetched at the program counter. Its operands are read from a register file with two read ports and one write port. An adder forms a sum, data memory is accessed, and the result is written back. Instruction and data memories are internal word arrays of parameterised depth. The instruction memory is filled through a load port while the core is held in reset. The core starts at address 0 when reset is released.

Seven operations are supported:
- add, with two registers or with a register and a literal;
- load, with the address as the sum of two registers or as a register plus a literal;
- store;
- a relative branch that tests a latched zero flag;
- a jump to a computed address.

Each clock the core reports its program counter, any register write (strobe, index, value) and any data-memory write (strobe, byte address, value). An enclosing system or a trace monitor can follow execution from these ports.

Instruction format: opcode in bits 31:26. Field A in bits 25:21 is the destination, or the store-data source for stores. Field B in bits 20:16 is the base/first source. Field C in bits 15:11 is the second source. The literal in bits 15:0 is sign-extended to 32 bits. Addresses are byte addresses; memories ignore address bits 1:0.

Top module: `ft_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pc_o` is 0. While `rst` is high, `wb_en_o` and `st_en_o` are 0. All registers and the zero flag are 0 after reset.
- R2: Opcode 1 (register add) writes field B's register plus field C's register into field A's register.
- R3: Opcode 2 (literal add) writes field B's register plus the sign-extended 16-bit literal into field A's register.
- R4: Opcode 3 (double-indexed load) writes the data word at byte address B-register plus C-register into field A's register.
- R5: Opcode 4 (literal-offset load) writes the data word at byte address B-register plus sign-extended literal into field A's register.
- R6: Opcode 5 (store) writes field A's register to the data word at byte address B-register plus sign-extended literal. It shows that address and value on the store ports and makes no register write.
- R7: Opcode 6 (branch) sets the next PC to PC+4+(sign-extended literal shifted left by 2) when the zero flag is 1, and to PC+4 otherwise.
- R8: The zero flag is set to (sum == 0) by opcodes 1 and 2 only. All other opcodes leave it unchanged.
- R9: Opcode 7 (jump) sets the next PC to B-register plus sign-extended literal and makes no register write.
- R10: Register 0 always reads as 0. A write aimed at it is dropped and raises no `wb_en_o`.
- R11: Opcode 0 and opcodes 8 to 63 write no register and no memory, leave the flag unchanged, and advance the PC by 4.
- R12: An instruction that reads and writes the same register uses the value held before that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Instruction memory write strobe |
| load_addr | input | 6 | Instruction memory word index |
| load_word | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Register write this cycle |
| wb_idx_o | output | 5 | Register written |
| wb_data_o | output | 32 | Value written |
| st_en_o | output | 1 | Data memory write this cycle |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store value |

## Verification
Two cases make functions meet within one cycle.

The first is a register read and a register write on the same index. An add that doubles a register into itself is run and judged against a model that updates its register array only after the whole instruction has been evaluated.

The second is the zero flag being produced by one instruction and consumed by the branch after it, with a store placed in between. This tests that only adds move the flag.

The reference model predicts the PC, the write-back and the store ports for every clock.

// File: rtl/ft_pkg.sv
package ft_pkg;

   localparam int XLEN   = 32;
   localparam int REG_AW = 5;
   localparam int OPW    = 6;

   localparam logic [OPW-1:0] OPC_NOP  = 6'd0;
   localparam logic [OPW-1:0] OPC_ADD  = 6'd1;
   localparam logic [OPW-1:0] OPC_ADDI = 6'd2;
   localparam logic [OPW-1:0] OPC_LDX  = 6'd3;
   localparam logic [OPW-1:0] OPC_LDI  = 6'd4;
   localparam logic [OPW-1:0] OPC_STR  = 6'd5;
   localparam logic [OPW-1:0] OPC_BEQ  = 6'd6;
   localparam logic [OPW-1:0] OPC_JMP  = 6'd7;

   typedef enum logic [1:0] {
      PC_SEQ = 2'd0,
      PC_BR  = 2'd1,
      PC_ALU = 2'd2
   } pcsel_e;

   typedef struct packed {
      logic rf_we;     // result goes to register file
      logic use_lit;   // adder second operand is the literal
      logic wb_mem;    // writeback takes memory data
      logic mem_we;    // data memory write
      logic flag_we;   // zero flag follows this sum
      logic b_from_a;  // port B reads field A (store data)
      logic is_branch;
      logic is_jump;
   } ctrl_t;

endpackage

// File: rtl/ft_wordmem.sv
module ft_wordmem #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   initial begin
      assert (DEPTH >= 2 && (1 << AW) == DEPTH)
         else $error("ft_wordmem: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] store_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store_q[waddr] <= wdata;
   end

   // combinational read: the whole instruction finishes in one clock
   assign rdata = store_q[raddr];

endmodule

// File: rtl/ft_decode.sv
module ft_decode
   import ft_pkg::*;
(
   input  logic [OPW-1:0] opcode,
   output ctrl_t          ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (opcode)
         OPC_ADD: begin
            ctrl.rf_we   = 1'b1;
            ctrl.flag_we = 1'b1;
         end
         OPC_ADDI: begin
            ctrl.rf_we   = 1'b1;
            ctrl.use_lit = 1'b1;
            ctrl.flag_we = 1'b1;
         end
         OPC_LDX: begin
            ctrl.rf_we  = 1'b1;
            ctrl.wb_mem = 1'b1;
         end
         OPC_LDI: begin
            ctrl.rf_we   = 1'b1;
            ctrl.wb_mem  = 1'b1;
            ctrl.use_lit = 1'b1;
         end
         OPC_STR: begin
            ctrl.mem_we   = 1'b1;
            ctrl.use_lit  = 1'b1;
            ctrl.b_from_a = 1'b1;
         end
         OPC_BEQ: ctrl.is_branch = 1'b1;
         OPC_JMP: begin
            ctrl.is_jump = 1'b1;
            ctrl.use_lit = 1'b1;
         end
         default: ctrl = '0;   // opcode 0 and every unassigned code
      endcase
   end

endmodule

// File: rtl/ft_regfile.sv
module ft_regfile #(
   parameter int WIDTH  = 32,
   parameter int NREG   = 32,
   parameter int NREAD  = 2,
   localparam int AW = $clog2(NREG)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        we,
   input  logic [AW-1:0]               waddr,
   input  logic [WIDTH-1:0]            wdata,
   input  logic [NREAD-1:0][AW-1:0]    raddr,
   output logic [NREAD-1:0][WIDTH-1:0] rdata
);

   initial begin
      assert (NREG >= 2 && (1 << AW) == NREG)
         else $error("ft_regfile: NREG must be a power of two");
      assert (NREAD >= 1)
         else $error("ft_regfile: need at least one read port");
   end

   logic [WIDTH-1:0] regs_q [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      end else if (we && waddr != '0) begin
         regs_q[waddr] <= wdata;
      end
   end

   // one independent read path per port; index 0 is hard-wired to zero
   for (genvar p = 0; p < NREAD; p++) begin : g_rport
      assign rdata[p] = (raddr[p] == '0) ? '0 : regs_q[raddr[p]];
   end

endmodule

// File: rtl/ft_alu.sv
module ft_alu #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             use_lit,
   input  logic             flag_we,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb_reg,
   input  logic [WIDTH-1:0] opb_lit,
   output logic [WIDTH-1:0] sum,
   output logic             zflag
);

   logic [WIDTH-1:0] opb;
   logic             zflag_q;

   assign opb = use_lit ? opb_lit : opb_reg;
   assign sum = opa + opb;

   always_ff @(posedge clk) begin
      if (rst)          zflag_q <= 1'b0;
      else if (flag_we) zflag_q <= (sum == '0);
   end

   assign zflag = zflag_q;

   // R8: only flag-writing instructions may move the flag
   p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !flag_we |=> $stable(zflag));

endmodule

// File: rtl/ft_pc_unit.sv
module ft_pc_unit
   import ft_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int BR_SHIFT = 2,
   parameter int STEP     = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  pcsel_e           sel,
   input  logic [WIDTH-1:0] lit_sx,
   input  logic [WIDTH-1:0] alu_sum,
   output logic [WIDTH-1:0] pc
);

   initial begin
      assert (BR_SHIFT >= 0 && BR_SHIFT < WIDTH)
         else $error("ft_pc_unit: bad BR_SHIFT");
   end

   logic [WIDTH-1:0] pc_q, seq_pc, br_pc, nxt_pc;

   assign seq_pc = pc_q + WIDTH'(STEP);
   assign br_pc  = seq_pc + (lit_sx << BR_SHIFT);

   always_comb begin
      unique case (sel)
         PC_BR:   nxt_pc = br_pc;
         PC_ALU:  nxt_pc = alu_sum;
         default: nxt_pc = seq_pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= nxt_pc;
   end

   assign pc = pc_q;

   p_pc_reset_r1: assert property (@(posedge clk)
      rst |=> (pc == '0));

   p_branch_tgt_r7: assert property (@(posedge clk) disable iff (rst)
      (sel == PC_BR) |=> (pc == $past(pc) + WIDTH'(STEP) + ($past(lit_sx) << BR_SHIFT)));

endmodule

// File: rtl/ft_core.sv
module ft_core
   import ft_pkg::*;
#(
   parameter int IMEM_DEPTH = 64,
   parameter int DMEM_DEPTH = 64,
   localparam int IAW = $clog2(IMEM_DEPTH),
   localparam int DAW = $clog2(DMEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [IAW-1:0]    load_addr,
   input  logic [XLEN-1:0]   load_word,
   output logic [XLEN-1:0]   pc_o,
   output logic              wb_en_o,
   output logic [REG_AW-1:0] wb_idx_o,
   output logic [XLEN-1:0]   wb_data_o,
   output logic              st_en_o,
   output logic [XLEN-1:0]   st_addr_o,
   output logic [XLEN-1:0]   st_data_o
);

   initial begin
      assert (XLEN == 32) else $error("ft_core: instruction format needs 32 bits");
      assert (IAW + 2 <= XLEN && DAW + 2 <= XLEN)
         else $error("ft_core: memory deeper than address space");
   end

   logic [XLEN-1:0]         pc, instr, lit_sx, alu_sum, dm_rdata;
   logic [1:0][REG_AW-1:0]  rf_raddr;
   logic [1:0][XLEN-1:0]    rf_rdata;
   logic [REG_AW-1:0]       fa, fb, fc;
   ctrl_t                   ctrl;
   logic                    zflag;
   pcsel_e                  pc_sel;

   // fetch
   ft_wordmem #(.WIDTH(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
      .clk   (clk),
      .we    (load_en),
      .waddr (load_addr),
      .wdata (load_word),
      .raddr (pc[IAW+1:2]),
      .rdata (instr)
   );

   // field split
   assign fa     = instr[25:21];
   assign fb     = instr[20:16];
   assign fc     = instr[15:11];
   assign lit_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

   ft_decode u_dec (
      .opcode (instr[31:26]),
      .ctrl   (ctrl)
   );

   // port 0 = base source, port 1 = second source or store data
   assign rf_raddr[0] = fb;
   assign rf_raddr[1] = ctrl.b_from_a ? fa : fc;

   ft_regfile #(.WIDTH(XLEN), .NREG(1 << REG_AW), .NREAD(2)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (wb_en_o),
      .waddr (fa),
      .wdata (wb_data_o),
      .raddr (rf_raddr),
      .rdata (rf_rdata)
   );

   ft_alu #(.WIDTH(XLEN)) u_alu (
      .clk     (clk),
      .rst     (rst),
      .use_lit (ctrl.use_lit),
      .flag_we (ctrl.flag_we),
      .opa     (rf_rdata[0]),
      .opb_reg (rf_rdata[1]),
      .opb_lit (lit_sx),
      .sum     (alu_sum),
      .zflag   (zflag)
   );

   ft_wordmem #(.WIDTH(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
      .clk   (clk),
      .we    (st_en_o),
      .waddr (alu_sum[DAW+1:2]),
      .wdata (rf_rdata[1]),
      .raddr (alu_sum[DAW+1:2]),
      .rdata (dm_rdata)
   );

   // next-PC selection: jump beats branch, branch only on a set flag
   always_comb begin
      if (ctrl.is_jump)                  pc_sel = PC_ALU;
      else if (ctrl.is_branch && zflag)  pc_sel = PC_BR;
      else                               pc_sel = PC_SEQ;
   end

   ft_pc_unit #(.WIDTH(XLEN), .BR_SHIFT(2), .STEP(4)) u_pc (
      .clk     (clk),
      .rst     (rst),
      .sel     (pc_sel),
      .lit_sx  (lit_sx),
      .alu_sum (alu_sum),
      .pc      (pc)
   );

   // writeback and trace ports
   assign pc_o      = pc;
   assign wb_en_o   = ctrl.rf_we && (fa != '0) && !rst;
   assign wb_idx_o  = fa;
   assign wb_data_o = ctrl.wb_mem ? dm_rdata : alu_sum;
   assign st_en_o   = ctrl.mem_we && !rst;
   assign st_addr_o = alu_sum;
   assign st_data_o = rf_rdata[1];

   p_store_no_wb_r6: assert property (@(posedge clk) disable iff (rst)
      st_en_o |-> !wb_en_o);

   p_r0_untouched_r10: assert property (@(posedge clk) disable iff (rst)
      wb_en_o |-> (wb_idx_o != '0));

   p_jump_tgt_r9: assert property (@(posedge clk) disable iff (rst)
      (pc_sel == PC_ALU) |=> (pc_o == $past(alu_sum)));

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |-> (!wb_en_o && !st_en_o));

endmodule

// File: tb/ft_core_test.sv
`timescale 1ns/1ps
module ft_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_en = 1'b0;
   logic [5:0]  load_addr = '0;
   logic [31:0] load_word = '0;
   logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
   logic        wb_en_o, st_en_o;
   logic [4:0]  wb_idx_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ft_core uut (
      .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
      .load_word(load_word), .pc_o(pc_o), .wb_en_o(wb_en_o),
      .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .st_en_o(st_en_o),
      .st_addr_o(st_addr_o), .st_data_o(st_data_o)
   );

   // behavioural model state
   bit [31:0] prog [64];
   bit [31:0] m_reg [32];
   bit [31:0] m_mem [64];
   bit [31:0] m_pc;
   bit        m_z;

   function automatic bit [31:0] enc_r(int op, int a, int b, int c);
      return {6'(op), 5'(a), 5'(b), 5'(c), 11'd0};
   endfunction

   function automatic bit [31:0] enc_l(int op, int a, int b, int lit);
      return {6'(op), 5'(a), 5'(b), 16'(lit)};
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(bit [31:0] ins, bit [5:0] prev_op);
      bit [5:0] op = ins[31:26];
      bit [4:0] a = ins[25:21], b = ins[20:16], c = ins[15:11];
      case (op)
         6'd1: return (a == 0 || b == 0) ? "R10" : (a == b || a == c) ? "R12" : "R2";
         6'd2: return (a == 0) ? "R10" : "R3";
         6'd3: return "R4";
         6'd4: return "R5";
         6'd5: return "R6";
         6'd6: return (prev_op != 6'd1 && prev_op != 6'd2) ? "R8" : "R7";
         6'd7: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic finish_run();
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      bit [5:0] prev_op;
      string    pc_tag;

      for (int i = 0; i < 64; i++) prog[i] = '0;
      prog[0]  = enc_l(2, 1, 0, 5);          // r1 = 5
      prog[1]  = enc_l(2, 2, 0, -5);         // r2 = -5
      prog[2]  = enc_r(1, 3, 1, 2);          // r3 = 0, flag set
      prog[3]  = enc_l(5, 1, 0, 8);          // mem[8] = r1, flag kept
      prog[4]  = enc_l(6, 0, 0, 1);          // taken, skips 5
      prog[5]  = enc_l(2, 4, 0, 99);
      prog[6]  = enc_l(4, 5, 0, 8);          // r5 = mem[8]
      prog[7]  = enc_l(2, 7, 0, 4);          // r7 = 4, flag clear
      prog[8]  = enc_r(3, 6, 7, 7);          // r6 = mem[r7+r7]
      prog[9]  = enc_l(6, 0, 0, 5);          // not taken
      prog[10] = enc_r(1, 0, 1, 1);          // write to r0 dropped
      prog[11] = enc_r(1, 8, 0, 0);          // r8 = 0, flag set
      prog[12] = enc_r(1, 1, 1, 1);          // r1 doubles itself
      prog[13] = enc_l(5, 1, 7, 12);         // mem[16] = r1
      prog[14] = enc_l(4, 9, 7, 12);         // r9 = mem[16]
      prog[15] = {6'h3F, 5'd9, 5'd1, 16'h1234};  // unassigned opcode
      prog[16] = enc_l(2, 10, 0, 80);        // r10 = 80
      prog[17] = enc_l(7, 0, 10, -4);        // jump to 76
      prog[18] = enc_l(2, 11, 0, 1);
      prog[19] = enc_l(2, 12, 12, -1);       // r12 = -1
      prog[20] = enc_l(2, 14, 0, 0);         // flag set
      prog[21] = enc_l(6, 0, 0, -1);         // branch to itself

      repeat (2) @(posedge clk);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         load_en = 1'b1; load_addr = 6'(i); load_word = prog[i];
      end
      @(negedge clk);
      load_en = 1'b0;
      #1;
      chk("R1", "pc in reset", pc_o, 32'h0);
      chk("R1", "wb_en in reset", {31'd0, wb_en_o}, 32'h0);
      chk("R1", "st_en in reset", {31'd0, st_en_o}, 32'h0);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < 32; i++) m_reg[i] = '0;
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
      m_pc = '0; m_z = 1'b0;
      prev_op = '0;
      pc_tag = "R1";

      for (int cyc = 0; cyc < 60; cyc++) begin
         bit [31:0] ins, lit, a_val, c_val, s_val, sum, nxt;
         bit [5:0]  op;
         bit [4:0]  fa;
         bit        e_wb, e_st;
         bit [31:0] e_wbd;
         string     tg;

         #1;
         ins   = prog[m_pc[7:2]];
         op    = ins[31:26];
         fa    = ins[25:21];
         lit   = {{16{ins[15]}}, ins[15:0]};
         a_val = m_reg[ins[20:16]];
         c_val = m_reg[ins[15:11]];
         s_val = m_reg[fa];
         tg    = tag_of(ins, prev_op);
         nxt   = m_pc + 4;
         e_wb  = 0; e_st = 0; e_wbd = '0; sum = '0;

         case (op)
            6'd1: begin sum = a_val + c_val; e_wbd = sum; e_wb = 1; end
            6'd2: begin sum = a_val + lit;   e_wbd = sum; e_wb = 1; end
            6'd3: begin sum = a_val + c_val; e_wbd = m_mem[sum[7:2]]; e_wb = 1; end
            6'd4: begin sum = a_val + lit;   e_wbd = m_mem[sum[7:2]]; e_wb = 1; end
            6'd5: begin sum = a_val + lit;   e_st = 1; end
            6'd6: if (m_z) nxt = m_pc + 4 + (lit << 2);
            6'd7: nxt = a_val + lit;
            default: ;
         endcase
         if (fa == 0) e_wb = 0;

         chk(pc_tag, "pc", pc_o, m_pc);
         chk(tg, "wb_en", {31'd0, wb_en_o}, {31'd0, e_wb});
         if (e_wb) begin
            chk(tg, "wb_idx", {27'd0, wb_idx_o}, {27'd0, fa});
            chk(tg, "wb_data", wb_data_o, e_wbd);
         end
         chk(tg, "st_en", {31'd0, st_en_o}, {31'd0, e_st});
         if (e_st) begin
            chk(tg, "st_addr", st_addr_o, sum);
            chk(tg, "st_data", st_data_o, s_val);
         end

         // state updates after the whole instruction is evaluated (R12)
         if (e_wb) m_reg[fa] = e_wbd;
         if (e_st) m_mem[sum[7:2]] = s_val;
         if (op == 6'd1 || op == 6'd2) m_z = (sum == 0);
         m_pc = nxt;
         prev_op = op;
         pc_tag = (op == 6'd6 || op == 6'd7 || op == 6'd0 || op > 6'd7) ? tg : "R11";
         @(negedge clk);
      end

      finish_run();
   end

endmodule